// File: doc/BRIEF.md
# Tone Transceiver Host Register Port

This block is the host-facing register port of a tone transceiver. A host reaches it over a 4-bit bus with three active-low strobes: chip select, read and write. One select line picks between the data pair and the control/status pair. The strobes are asynchronous to the block clock. They pass through a two-flop synchroniser, and every register action happens when the synchronised read or write strobe returns high.

Behind the port sit a transmit code register, a receive code register, two control registers and a status register. Control A and control B share one write address. A small pointer state machine steers the single control write that follows a write of A with its top bit set into B. The transmitter and the receiver report to the block with single-cycle pulses for "pause finished" and "digit registered", and with a delayed-steering level. The block keeps clear-on-read status flags and drives an active-low interrupt / call-progress pin.

The access machine has three states. ACC_IDLE moves to ACC_READ when chip select and read are both low, or to ACC_WRITE when chip select and write are both low. ACC_READ returns to ACC_IDLE on the rising edge of read, which completes the read. ACC_WRITE returns to ACC_IDLE on the rising edge of write, which commits the write. The pointer machine has two states. PTR_A moves to PTR_B on a control write whose bit 3 is 1. PTR_B always returns to PTR_A on the next control write.

Top module: `tone_host_if`

## Requirements
- R1: A write with rs=0 loads `din` into `tx_code` and gives exactly one `tx_load` pulse. A write with rs=1 is a control write.
- R2: A read with rs=0 returns the last code latched from `rx_code` on `digit_valid`. A read with rs=1 returns the status word: bit0 interrupt flag, bit1 transmit-empty, bit2 receive-full, bit3 the live `dly_steer` level.
- R3: A control write while the pointer is at A sets `tone_en` from bit0, `cp_mode` from bit1 and `irq_en` from bit2.
- R4: A control-A write with bit3=1 sends the next control write, and only that one, to control B, leaving control A unchanged. The control write after it goes to A again.
- R5: Control B drives `burst_off` from bit0 (0 means burst mode on), `test_mode` from bit1, `single_tone` from bit2 and `col_sel` from bit3.
- R6: `digit_valid` sets receive-full and the interrupt flag. A status read still returns them set, and both clear once that read ends.
- R7: `pause_done` sets transmit-empty and the interrupt flag only while `burst_off`=0. Transmit-empty is held clear while `burst_off`=1, and it clears at the end of a status read.
- R8: With `irq_en`=1, `cp_mode`=0 and `test_mode`=0, `irq_cp_n` is low exactly while the interrupt flag is set. With `irq_en`=0 and no test routing, the pin stays high.
- R9: With `irq_en`=1 and `cp_mode`=1, `irq_cp_n` follows `cp_square`.
- R10: With `test_mode`=1 and `cp_mode`=0, `irq_cp_n` follows `dly_steer`. This routing takes precedence over the interrupt flag.
- R11: `dout_oe` is 1 only while `cs_n` and `rd_n` are both low. At all other times `dout` is 0.
- R12: A write strobe while `cs_n` is high changes no register.
- R13: After reset both control registers are zero, the pointer is at A, all status flags are clear and `irq_cp_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rs | input | 1 | Register select: 0 data pair, 1 control/status |
| din | input | 4 | Host write data |
| dout | output | 4 | Host read data, 0 when not enabled |
| dout_oe | output | 1 | Read-data drive enable for the pad |
| tone_en | output | 1 | Control A bit0, tone output enable |
| cp_mode | output | 1 | Control A bit1, call-progress mode |
| irq_en | output | 1 | Control A bit2, interrupt enable |
| burst_off | output | 1 | Control B bit0, burst mode disabled |
| test_mode | output | 1 | Control B bit1, steering test routing |
| single_tone | output | 1 | Control B bit2, single tone select |
| col_sel | output | 1 | Control B bit3, column group select |
| tx_code | output | 4 | Transmit code register |
| tx_load | output | 1 | One-cycle pulse when the transmit code is written |
| rx_code | input | 4 | Code from the receiver |
| digit_valid | input | 1 | Pulse: receiver registered a digit |
| pause_done | input | 1 | Pulse: burst pause finished |
| dly_steer | input | 1 | Delayed steering level |
| cp_square | input | 1 | Limited call-progress square wave |
| irq_cp_n | output | 1 | Interrupt / call-progress pin, active low |

## Verification
The bench goes after the shared control address. It walks the pointer through A, B, A with varied bit3 values. A design that left the pointer at B, or wrote A at the same time, would show the wrong control outputs on the following writes. It reads status while flags are set and expects the set value on the bus, then zero on a second read. A design that cleared the flags at the start of the read would return zeros, and one that never cleared them would keep the interrupt pin low. Pause pulses arrive while burst mode is off and must leave transmit-empty clear. Pin routing is checked across all irq_en / cp_mode / test_mode combinations, so a wrong priority shows on the pin. Random sequences mixing bus cycles and events are compared against a bench model of the flags.

// File: rtl/tone_host_pkg.sv
package tone_host_pkg;
    localparam int DATA_W = 4;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_state_t;

    typedef enum logic {
        PTR_A = 1'b0,
        PTR_B = 1'b1
    } ctl_ptr_t;

    typedef struct packed {
        logic irq_en;
        logic cp_mode;
        logic tone_en;
    } ctl_a_t;

    typedef struct packed {
        logic col_sel;
        logic single;
        logic test;
        logic burst_off;
    } ctl_b_t;
endpackage

// File: rtl/thi_sync.sv
module thi_sync #(
    parameter int              W       = 7,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/thi_access_fsm.sv
module thi_access_fsm
    import tone_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              rd_s,
    input  logic              wr_s,
    input  logic              rs_s,
    input  logic [DATA_W-1:0] din_s,
    output ctl_a_t            ctl_a,
    output ctl_b_t            ctl_b,
    output logic [DATA_W-1:0] tx_code,
    output logic              tx_load,
    output logic              stat_rd_done
);
    acc_state_t st_q, st_d;
    ctl_ptr_t   ptr_q;
    logic       rs_lat;
    logic       wr_fire, tx_wr, ctl_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACC_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACC_IDLE: begin
                if (!cs_s && !rd_s)      st_d = ACC_READ;
                else if (!cs_s && !wr_s) st_d = ACC_WRITE;
            end
            ACC_READ:  if (rd_s) st_d = ACC_IDLE;
            ACC_WRITE: if (wr_s) st_d = ACC_IDLE;
            default:   st_d = ACC_IDLE;
        endcase
    end

    // outputs of the access machine
    always_comb begin
        stat_rd_done = 1'b0;
        wr_fire      = 1'b0;
        unique case (st_q)
            ACC_READ:  stat_rd_done = rd_s && rs_lat;
            ACC_WRITE: wr_fire      = wr_s;
            default: ;
        endcase
    end

    assign tx_wr  = wr_fire && !rs_s;
    assign ctl_wr = wr_fire &&  rs_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_lat  <= 1'b0;
            ptr_q   <= PTR_A;
            ctl_a   <= '0;
            ctl_b   <= '0;
            tx_code <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= tx_wr;
            if (st_q == ACC_IDLE) rs_lat <= rs_s;
            if (tx_wr) tx_code <= din_s;
            if (ctl_wr) begin
                unique case (ptr_q)
                    PTR_A: begin
                        ctl_a <= din_s[2:0];
                        ptr_q <= din_s[3] ? PTR_B : PTR_A;
                    end
                    PTR_B: begin
                        ctl_b <= din_s;
                        ptr_q <= PTR_A;
                    end
                    default: ptr_q <= PTR_A;
                endcase
            end
        end
    end

    a_r4_b_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ptr_q == PTR_B) |=> (ptr_q == PTR_A));
    a_r4_a_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ptr_q == PTR_B) |=> $stable(ctl_a));
    a_r12_idle_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ACC_IDLE) |=> !tx_load);
endmodule

// File: rtl/thi_status.sv
module thi_status
    import tone_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              digit_valid,
    input  logic [DATA_W-1:0] rx_code,
    input  logic              pause_done,
    input  logic              burst_off,
    input  logic              dly_steer,
    input  logic              stat_rd_done,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rx_data
);
    logic irq_q, txe_q, rxf_q;
    logic rx_set, tx_set;

    assign rx_set = digit_valid;
    assign tx_set = pause_done && !burst_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            txe_q   <= 1'b0;
            rxf_q   <= 1'b0;
            rx_data <= '0;
        end else begin
            if (rx_set) rx_data <= rx_code;

            if (rx_set)            rxf_q <= 1'b1;
            else if (stat_rd_done) rxf_q <= 1'b0;

            if (burst_off)         txe_q <= 1'b0;
            else if (tx_set)       txe_q <= 1'b1;
            else if (stat_rd_done) txe_q <= 1'b0;

            if (rx_set || tx_set)  irq_q <= 1'b1;
            else if (stat_rd_done) irq_q <= 1'b0;
        end
    end

    assign status = {dly_steer, rxf_q, txe_q, irq_q};

    a_r7_no_empty_nonburst: assert property (@(posedge clk) disable iff (!rst_n)
        burst_off |=> !txe_q);
    a_r6_set_on_digit: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> (irq_q && rxf_q));
    a_r6_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_done && !rx_set && !tx_set) |=> (!irq_q && !rxf_q && !txe_q));
    a_r2_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !digit_valid |=> $stable(rx_data));
endmodule

// File: rtl/thi_pin_mux.sv
module thi_pin_mux (
    input  logic irq_en,
    input  logic cp_mode,
    input  logic test_mode,
    input  logic irq_flag,
    input  logic dly_steer,
    input  logic cp_square,
    output logic irq_cp_n
);
    always_comb begin
        if (irq_en && cp_mode)         irq_cp_n = cp_square;
        else if (test_mode && !cp_mode) irq_cp_n = dly_steer;
        else if (irq_en)               irq_cp_n = !irq_flag;
        else                           irq_cp_n = 1'b1;
    end
endmodule

// File: rtl/tone_host_if.sv
module tone_host_if
    import tone_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              rs,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              tone_en,
    output logic              cp_mode,
    output logic              irq_en,
    output logic              burst_off,
    output logic              test_mode,
    output logic              single_tone,
    output logic              col_sel,
    output logic [DATA_W-1:0] tx_code,
    output logic              tx_load,
    input  logic [DATA_W-1:0] rx_code,
    input  logic              digit_valid,
    input  logic              pause_done,
    input  logic              dly_steer,
    input  logic              cp_square,
    output logic              irq_cp_n
);
    localparam int BUS_W = DATA_W + 4;
    localparam logic [BUS_W-1:0] BUS_RST = {3'b111, 1'b0, {DATA_W{1'b0}}};

    logic [BUS_W-1:0]  bus_s;
    logic              cs_s, rd_s, wr_s, rs_s;
    logic [DATA_W-1:0] din_s;
    ctl_a_t            ctl_a;
    ctl_b_t            ctl_b;
    logic              stat_rd_done;
    logic [DATA_W-1:0] status, rx_data;

    thi_sync #(.W(BUS_W), .STAGES(2), .RST_VAL(BUS_RST)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, rd_n, wr_n, rs, din}),
        .q(bus_s)
    );
    assign {cs_s, rd_s, wr_s, rs_s, din_s} = bus_s;

    thi_access_fsm u_acc (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .rd_s(rd_s), .wr_s(wr_s), .rs_s(rs_s), .din_s(din_s),
        .ctl_a(ctl_a), .ctl_b(ctl_b),
        .tx_code(tx_code), .tx_load(tx_load),
        .stat_rd_done(stat_rd_done)
    );

    thi_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .digit_valid(digit_valid), .rx_code(rx_code),
        .pause_done(pause_done), .burst_off(ctl_b.burst_off),
        .dly_steer(dly_steer), .stat_rd_done(stat_rd_done),
        .status(status), .rx_data(rx_data)
    );

    thi_pin_mux u_pin (
        .irq_en(ctl_a.irq_en), .cp_mode(ctl_a.cp_mode), .test_mode(ctl_b.test),
        .irq_flag(status[0]), .dly_steer(dly_steer), .cp_square(cp_square),
        .irq_cp_n(irq_cp_n)
    );

    assign tone_en     = ctl_a.tone_en;
    assign cp_mode     = ctl_a.cp_mode;
    assign irq_en      = ctl_a.irq_en;
    assign burst_off   = ctl_b.burst_off;
    assign test_mode   = ctl_b.test;
    assign single_tone = ctl_b.single;
    assign col_sel     = ctl_b.col_sel;

    assign dout_oe = !cs_n && !rd_n;
    assign dout    = dout_oe ? (rs ? status : rx_data) : '0;

    a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));
endmodule

// File: tb/tone_host_if_tb.sv
`timescale 1ns/1ps
module tone_host_if_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rs = 1'b0;
    logic [3:0] din = '0, rx_code = '0;
    logic digit_valid = 1'b0, pause_done = 1'b0, dly_steer = 1'b0, cp_square = 1'b0;
    logic [3:0] dout, tx_code;
    logic dout_oe, tone_en, cp_mode, irq_en, burst_off, test_mode, single_tone, col_sel;
    logic tx_load, irq_cp_n;

    always #2.5 clk = ~clk;

    tone_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .rs(rs),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .tone_en(tone_en), .cp_mode(cp_mode), .irq_en(irq_en),
        .burst_off(burst_off), .test_mode(test_mode), .single_tone(single_tone),
        .col_sel(col_sel), .tx_code(tx_code), .tx_load(tx_load),
        .rx_code(rx_code), .digit_valid(digit_valid), .pause_done(pause_done),
        .dly_steer(dly_steer), .cp_square(cp_square), .irq_cp_n(irq_cp_n)
    );

    int errors = 0, checks = 0, loads = 0;
    bit done = 1'b0;
    logic [2:0] m_a = '0;
    logic [3:0] m_b = '0, m_tx = '0, m_rx = '0;
    logic m_ptr = 1'b0, m_irq = 1'b0, m_txe = 1'b0, m_rxf = 1'b0;

    always @(posedge clk) if (tx_load) loads++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_pin();
        if (m_a[2] && m_a[1]) return cp_square;
        if (m_b[1] && !m_a[1]) return dly_steer;
        if (m_a[2]) return !m_irq;
        return 1'b1;
    endfunction

    function automatic logic [3:0] exp_stat();
        return {dly_steer, m_rxf, m_txe, m_irq};
    endfunction

    task automatic bus_write(input logic r, input logic [3:0] d, input logic sel_n);
        rs = r; din = d;
        @(negedge clk) cs_n = sel_n;
        repeat (2) @(negedge clk);
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        if (!sel_n) begin
            if (!r) m_tx = d;
            else if (!m_ptr) begin m_a = d[2:0]; m_ptr = d[3]; end
            else begin m_b = d; m_ptr = 1'b0; if (d[0]) m_txe = 1'b0; end
        end
    endtask

    task automatic bus_read(input logic r, output logic [3:0] v, output logic oe);
        rs = r;
        @(negedge clk) begin cs_n = 1'b0; rd_n = 1'b0; end
        repeat (3) @(negedge clk);
        v = dout; oe = dout_oe;
        rd_n = 1'b1;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        if (r) begin m_irq = 1'b0; m_txe = 1'b0; m_rxf = 1'b0; end
    endtask

    task automatic ev_digit(input logic [3:0] c);
        @(negedge clk) begin rx_code = c; digit_valid = 1'b1; end
        @(negedge clk) digit_valid = 1'b0;
        m_rx = c; m_rxf = 1'b1; m_irq = 1'b1;
    endtask

    task automatic ev_pause();
        @(negedge clk) pause_done = 1'b1;
        @(negedge clk) pause_done = 1'b0;
        if (!m_b[0]) begin m_txe = 1'b1; m_irq = 1'b1; end
    endtask

    task automatic chk_ctl(input string tag);
        chk({tag, " R3 ctlA"}, {irq_en, cp_mode, tone_en}, m_a);
        chk({tag, " R5 ctlB"}, {col_sel, single_tone, test_mode, burst_off}, m_b);
        chk({tag, " R8 pin"}, irq_cp_n, exp_pin());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [3:0] v;
        logic oe;
        int lc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 ctl", {irq_en, cp_mode, tone_en, col_sel, single_tone, test_mode, burst_off}, 0);
        chk("R13 pin", irq_cp_n, 1);
        chk("R11 idle oe", dout_oe, 0);
        bus_read(1'b1, v, oe);
        chk("R13 status", v, 0);
        chk("R11 oe during read", oe, 1);
        chk("R11 oe after read", dout_oe, 0);
        chk("R11 dout quiet", dout, 0);

        // R1 transmit write
        lc = loads;
        bus_write(1'b0, 4'd9, 1'b0);
        chk("R1 tx_code", tx_code, 9);
        chk("R1 one load", loads - lc, 1);

        // R4 pointer steering
        bus_write(1'b1, 4'b1101, 1'b0);
        chk_ctl("R4 A with sel");
        bus_write(1'b1, 4'b0110, 1'b0);
        chk_ctl("R4 B write");
        chk("R4 A unchanged", {irq_en, cp_mode, tone_en}, 3'b101);
        bus_write(1'b1, 4'b0100, 1'b0);
        chk_ctl("R4 back to A");
        chk("R4 B kept", {col_sel, single_tone, test_mode, burst_off}, 4'b0110);

        // R12 ignored write with chip select high
        lc = loads;
        bus_write(1'b1, 4'b0011, 1'b1);
        chk_ctl("R12 ignored ctl");
        bus_write(1'b0, 4'd2, 1'b1);
        chk("R12 tx kept", tx_code, 9);
        chk("R12 no load", loads - lc, 0);

        // clear test routing: B = 0 (burst on)
        bus_write(1'b1, 4'b1100, 1'b0);
        bus_write(1'b1, 4'b0000, 1'b0);
        chk_ctl("R5 B cleared");

        // R6 digit then status read
        ev_digit(4'd7);
        @(negedge clk);
        chk("R8 pin low on flag", irq_cp_n, 0);
        bus_read(1'b0, v, oe);
        chk("R2 rx data", v, 7);
        bus_read(1'b1, v, oe);
        chk("R6 read shows flags", v, 4'b0101);
        bus_read(1'b1, v, oe);
        chk("R6 cleared after read", v, 0);
        chk("R8 pin released", irq_cp_n, 1);

        // R7 pause in burst mode, then with burst off
        ev_pause();
        bus_read(1'b1, v, oe);
        chk("R7 tx empty set", v, 4'b0011);
        bus_write(1'b1, 4'b1100, 1'b0);
        bus_write(1'b1, 4'b0001, 1'b0);
        ev_pause();
        bus_read(1'b1, v, oe);
        chk("R7 no set when burst off", v, 0);
        ev_pause();
        bus_write(1'b1, 4'b1100, 1'b0);
        bus_write(1'b1, 4'b0000, 1'b0);
        ev_pause();
        @(negedge clk);
        bus_write(1'b1, 4'b1100, 1'b0);
        bus_write(1'b1, 4'b0001, 1'b0);
        chk("R7 empty forced clear", irq_cp_n, 0);
        bus_read(1'b1, v, oe);
        chk("R7 status after burst off", v, 4'b0001);

        // R9 call-progress passthrough
        bus_write(1'b1, 4'b0110, 1'b0);
        cp_square = 1'b1; @(negedge clk);
        chk("R9 cp high", irq_cp_n, 1);
        cp_square = 1'b0; @(negedge clk);
        chk("R9 cp low", irq_cp_n, 0);

        // R10 test routing over interrupt
        bus_write(1'b1, 4'b1100, 1'b0);
        bus_write(1'b1, 4'b0010, 1'b0);
        ev_digit(4'd3);
        dly_steer = 1'b1; @(negedge clk);
        chk("R10 follows steer high", irq_cp_n, 1);
        dly_steer = 1'b0; @(negedge clk);
        chk("R10 follows steer low", irq_cp_n, 0);
        dly_steer = 1'b1; @(negedge clk);
        bus_read(1'b1, v, oe);
        chk("R2 status steer bit", v, 4'b1101);
        dly_steer = 1'b0;

        // random mix
        void'($urandom(32'd1971));
        for (int i = 0; i < 120; i++) begin
            int op;
            op = $urandom_range(0, 6);
            case (op)
                0, 1: bus_write(1'b1, 4'($urandom_range(0, 15)), 1'b0);
                2: begin
                    logic [3:0] d;
                    d = 4'($urandom_range(0, 15));
                    bus_write(1'b0, d, 1'b0);
                    chk("R1 rand tx", tx_code, d);
                end
                3: ev_digit(4'($urandom_range(0, 15)));
                4: ev_pause();
                5: begin
                    logic [3:0] e;
                    e = exp_stat();
                    bus_read(1'b1, v, oe);
                    chk("R6 rand status", v, e);
                end
                default: begin
                    bus_read(1'b0, v, oe);
                    chk("R2 rand rx", v, m_rx);
                end
            endcase
            dly_steer = 1'($urandom_range(0, 1));
            cp_square = 1'($urandom_range(0, 1));
            @(negedge clk);
            chk_ctl("rand");
        end
        finish_run();
    end
endmodule